// File: doc/BRIEF.md
# Serial Disk Byte Transfer Controller

This block sits between a CPU register bus and a bit-serial storage drive. Data moves one bit per strobe of a bit-clock enable through an 8-bit shift register, least significant bit first, either out to the drive or in from it. Every eighth bit a byte-ready flag rises. At that moment the assembled byte is copied into a receive holding register, and the next outgoing byte is taken from a transmit holding register. Software therefore has a full byte time to service each byte.

A running CRC-16 (reflected, polynomial 0x8408, zero while disabled) covers every bit that crosses the serial line. In transmit mode a control bit makes the engine send the CRC itself, low byte first. In receive mode, once the two CRC bytes have arrived, a status bit reports whether the residue is nonzero. An optional interrupt is raised on every byte-ready event. A master enable input freezes the whole block and silences the bus and the interrupt.

The register select is two bits. Select 0 is transmit data (write). Select 1 is control (write, and readable). Select 2 is receive data (read). Select 3 is status (read).

Control bits:
- bit 0: run; 0 holds the bit timing in reset.
- bit 1: motor halt; 1 stops transfers and drives `motor_stop`.
- bit 2: direction; 0 transmit, 1 receive.
- bit 3: mirroring select.
- bit 4: CRC send.
- bit 5: reads as 1.
- bit 6: CRC enable.
- bit 7: byte interrupt enable.

Status bits:
- bit 1: byte-ready.
- bit 4: CRC error.
- bit 6: head at innermost position.
- bit 7: medium accessible.
- All other status bits read 0.

Top module: `serial_disk_port`

## Requirements
- R1: In transmit mode (control bit 2 = 0) `ser_out` presents shift-register bit 0 and each bit strobe shifts right. At each byte boundary the shift register loads the transmit holding register. The first byte after the timing reset is released is 0x00.
- R2: In receive mode (control bit 2 = 1) each bit strobe shifts `ser_in` into bit 7, LSB first. At each byte boundary the completed byte is copied to the receive register (select 2).
- R3: Status bit 1 (byte-ready) is set on the eighth bit strobe. It is cleared by a transmit-data write, a receive-data read or a status read, and a set in the same cycle wins over a clear.
- R4: While control bit 0 is 0 the bit count and shift register are held at zero. While control bit 1 is 1 bit strobes are ignored. `motor_stop` follows control bit 1 and `mirror_h` follows control bit 3.
- R5: Reading select 1 returns the stored control byte with bit 5 forced to 1. The reset value reads 0x22.
- R6: With control bit 6 = 1 the CRC-16 (poly 0x8408, reflected, LSB first) is updated with every serial bit in either direction; with bit 6 = 0 it is held at zero. In transmit mode with control bit 4 = 1, each byte boundary loads the CRC low byte, so the CRC goes out low byte then high byte.
- R7: In receive mode with control bits 4 and 6 set, status bit 4 is updated at every byte boundary to (CRC residue nonzero). It is cleared while control bit 6 is 0.
- R8: With control bit 7 = 1 a byte boundary sets a pending interrupt shown on `irq`. A control write, a transmit-data write or a receive-data read clears it, and a status read does not.
- R9: Status bit 7 mirrors `media_ok` and bit 6 mirrors `head_inner`; bits 0, 2, 3 and 5 read 0.
- R10: While `disk_io_en` is 0, register writes are ignored, reads return 0, bit strobes have no effect, `irq` is 0 and any pending interrupt is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disk_io_en | input | 1 | Master enable for the whole block |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from select |
| bit_tick | input | 1 | Bit-clock enable, one pulse per serial bit |
| ser_in | input | 1 | Serial data from the drive |
| ser_out | output | 1 | Serial data to the drive |
| media_ok | input | 1 | Medium readable/writable |
| head_inner | input | 1 | Head at innermost position |
| motor_stop | output | 1 | Motor halt request |
| mirror_h | output | 1 | Mirroring select |
| irq | output | 1 | Byte interrupt |

## Verification
The properties assume that every bus access lasts one cycle and that `bus_rd` and `bus_wr` are never high together. They also assume that a control or transmit-data write whose interrupt clear is checked does not coincide with a bit strobe. The stimulus separates every register access from every bit strobe by at least one clock, so an acknowledge never lands in the same cycle as a byte boundary. The drive inputs `media_ok` and `head_inner` change only between accesses.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
    // register selects
    localparam logic [1:0] SEL_TXD  = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_RXD  = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    // control bit positions
    localparam int C_RUN   = 0;
    localparam int C_HALT  = 1;
    localparam int C_RX    = 2;
    localparam int C_MIRH  = 3;
    localparam int C_CRCTX = 4;
    localparam int C_ONE   = 5;
    localparam int C_CRCEN = 6;
    localparam int C_IRQEN = 7;

    // status bit positions
    localparam int S_BYTE  = 1;
    localparam int S_CRCER = 4;
    localparam int S_INNER = 6;
    localparam int S_MEDIA = 7;
endpackage

// File: rtl/sdp_bus_decode.sv
module sdp_bus_decode
    import sdp_pkg::*;
(
    input  logic       en,
    input  logic       wr,
    input  logic       rd,
    input  logic [1:0] sel,
    output logic       wr_txd,
    output logic       wr_ctrl,
    output logic       rd_rxd,
    output logic       rd_stat,
    output logic       rd_ctrl
);
    always_comb begin
        wr_txd  = en && wr && (sel == SEL_TXD);
        wr_ctrl = en && wr && (sel == SEL_CTRL);
        rd_rxd  = en && rd && (sel == SEL_RXD);
        rd_stat = en && rd && (sel == SEL_STAT);
        rd_ctrl = en && rd && (sel == SEL_CTRL);
    end
endmodule

// File: rtl/sdp_crc_step.sv
module sdp_crc_step #(
    parameter int          CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_out
);
    logic fb;
    always_comb begin
        fb      = crc_in[0] ^ bit_in;
        crc_out = (crc_in >> 1) ^ (fb ? CRC_POLY : '0);
    end
endmodule

// File: rtl/sdp_read_mux.sv
module sdp_read_mux #(
    parameter int DATA_W = 8
) (
    input  logic              rd_ctrl,
    input  logic              rd_rxd,
    input  logic              rd_stat,
    input  logic [DATA_W-1:0] ctrl_val,
    input  logic [DATA_W-1:0] rxd_val,
    input  logic [DATA_W-1:0] stat_val,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_ctrl) rdata = ctrl_val;
        if (rd_rxd)  rdata = rxd_val;
        if (rd_stat) rdata = stat_val;
    end
endmodule

// File: rtl/serial_disk_port.sv
module serial_disk_port
    import sdp_pkg::*;
#(
    parameter int               DATA_W   = 8,
    parameter int               CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disk_io_en,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bit_tick,
    input  logic              ser_in,
    output logic              ser_out,
    input  logic              media_ok,
    input  logic              head_inner,
    output logic              motor_stop,
    output logic              mirror_h,
    output logic              irq
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1) << C_HALT;

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] txbuf;
        logic [DATA_W-1:0] rxbuf;
        logic [DATA_W-1:0] ctrl;
        logic [CNT_W-1:0]  bitcnt;
        logic [CRC_W-1:0]  crc;
        logic              flag;
        logic              crc_err;
        logic              irq_pend;
    } state_t;

    state_t s_d, s_q;

    logic wr_txd, wr_ctrl, rd_rxd, rd_stat, rd_ctrl;
    logic run_active, rx_mode, line_bit, byte_done;
    logic [DATA_W-1:0] sh_next, ctrl_view, stat_view;
    logic [CRC_W-1:0]  crc_stepped;

    sdp_bus_decode u_dec (
        .en      (disk_io_en),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .sel     (bus_addr),
        .wr_txd  (wr_txd),
        .wr_ctrl (wr_ctrl),
        .rd_rxd  (rd_rxd),
        .rd_stat (rd_stat),
        .rd_ctrl (rd_ctrl)
    );

    sdp_crc_step #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
        .crc_in  (s_q.crc),
        .bit_in  (line_bit),
        .crc_out (crc_stepped)
    );

    always_comb begin
        ctrl_view = s_q.ctrl;
        ctrl_view[C_ONE] = 1'b1;
        stat_view = '0;
        stat_view[S_BYTE]  = s_q.flag;
        stat_view[S_CRCER] = s_q.crc_err;
        stat_view[S_INNER] = head_inner;
        stat_view[S_MEDIA] = media_ok;
    end

    sdp_read_mux #(.DATA_W(DATA_W)) u_mux (
        .rd_ctrl  (rd_ctrl),
        .rd_rxd   (rd_rxd),
        .rd_stat  (rd_stat),
        .ctrl_val (ctrl_view),
        .rxd_val  (s_q.rxbuf),
        .stat_val (stat_view),
        .rdata    (bus_rdata)
    );

    // next-state logic
    always_comb begin
        s_d        = s_q;
        rx_mode    = s_q.ctrl[C_RX];
        run_active = disk_io_en && s_q.ctrl[C_RUN] && !s_q.ctrl[C_HALT];
        line_bit   = rx_mode ? ser_in : s_q.shreg[0];
        sh_next    = rx_mode ? {ser_in, s_q.shreg[DATA_W-1:1]} : (s_q.shreg >> 1);
        byte_done  = 1'b0;

        if (wr_txd)  s_d.txbuf = bus_wdata;
        if (wr_ctrl) s_d.ctrl  = bus_wdata;

        if (!s_q.ctrl[C_RUN]) begin
            s_d.bitcnt = '0;
            s_d.shreg  = '0;
        end else if (run_active && bit_tick) begin
            s_d.shreg = sh_next;
            if (s_q.ctrl[C_CRCEN]) s_d.crc = crc_stepped;
            if (s_q.bitcnt == LAST_BIT) begin
                byte_done  = 1'b1;
                s_d.bitcnt = '0;
                if (rx_mode) begin
                    s_d.rxbuf = sh_next;
                    if (s_q.ctrl[C_CRCTX] && s_q.ctrl[C_CRCEN])
                        s_d.crc_err = (crc_stepped != '0);
                end else if (s_q.ctrl[C_CRCTX]) begin
                    s_d.shreg = crc_stepped[DATA_W-1:0];
                end else begin
                    s_d.shreg = s_q.txbuf;
                end
            end else begin
                s_d.bitcnt = s_q.bitcnt + 1'b1;
            end
        end

        if (!s_q.ctrl[C_CRCEN]) begin
            s_d.crc     = '0;
            s_d.crc_err = 1'b0;
        end

        if (wr_txd || rd_rxd || rd_stat) s_d.flag = 1'b0;
        if (byte_done)                   s_d.flag = 1'b1;

        if (wr_ctrl || wr_txd || rd_rxd)            s_d.irq_pend = 1'b0;
        if (byte_done && s_q.ctrl[C_IRQEN])         s_d.irq_pend = 1'b1;
        if (!disk_io_en)                            s_d.irq_pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ctrl <= CTRL_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign ser_out    = (run_active && !s_q.ctrl[C_RX]) ? s_q.shreg[0] : 1'b0;
    assign motor_stop = s_q.ctrl[C_HALT];
    assign mirror_h   = s_q.ctrl[C_MIRH];
    assign irq        = s_q.irq_pend && disk_io_en;
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disk_io_en,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bit_tick,
    input logic              media_ok,
    input logic              head_inner,
    input logic              motor_stop,
    input logic              irq,
    input logic              flag
);
    a_r10_irq_silent_off: assert property (@(posedge clk) disable iff (!rst_n)
        !disk_io_en |-> !irq);

    a_r10_read_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!disk_io_en && bus_rd) |-> (bus_rdata == '0));

    a_r5_ctrl_bit5_set: assert property (@(posedge clk) disable iff (!rst_n)
        (disk_io_en && bus_rd && bus_addr == 2'd1) |-> bus_rdata[5]);

    a_r8_write_acks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (disk_io_en && bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd1) && !bit_tick) |=> !irq);

    a_r3_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(bit_tick && disk_io_en));

    a_r4_halt_blocks_flag: assert property (@(posedge clk) disable iff (!rst_n)
        motor_stop |=> !$rose(flag));

    a_r9_drive_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (disk_io_en && bus_rd && bus_addr == 2'd3) |->
            (bus_rdata[7] == media_ok && bus_rdata[6] == head_inner && bus_rdata[0] == 1'b0));
endmodule

bind serial_disk_port sdp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disk_io_en (disk_io_en),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .bit_tick   (bit_tick),
    .media_ok   (media_ok),
    .head_inner (head_inner),
    .motor_stop (motor_stop),
    .irq        (irq),
    .flag       (s_q.flag)
);

// File: tb/serial_disk_port_test.sv
module serial_disk_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic [1:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdat = '0;
    logic [7:0] rdat;
    logic       tick = 1'b0, sin = 1'b0;
    logic       sout, mstop, mirh, irq;
    logic       media = 1'b1, inner = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_wr = 1'b0;
    logic       obs[$];
    logic [7:0] expq[$];

    always #10 clk = ~clk;

    serial_disk_port uut (
        .clk(clk), .rst_n(rst_n), .disk_io_en(en), .bus_addr(addr),
        .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdat), .bus_rdata(rdat),
        .bit_tick(tick), .ser_in(sin), .ser_out(sout),
        .media_ok(media), .head_inner(inner),
        .motor_stop(mstop), .mirror_h(mirh), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = r[0] ^ b[i];
            r = r >> 1;
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdat = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 d = rdat;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic one_tick(input logic b);
        @(negedge clk); tick = 1'b1; sin = b;
        #1 if (mon_wr) obs.push_back(sout);
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic feed_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) one_tick(b[i]);
    endtask

    task automatic peek();
        @(negedge clk); #1;
    endtask

    // monitor: assemble serial output and compare with expected queue
    always @(negedge clk) begin : mon
        logic [7:0] got;
        logic [7:0] exp_b;
        #2;
        if (obs.size() >= 8) begin
            for (int i = 0; i < 8; i++) got[i] = obs.pop_front();
            if (expq.size() == 0) begin
                chk(1'b0, "R1 unexpected byte", got, 0);
            end else begin
                exp_b = expq.pop_front();
                chk(got == exp_b, "R1/R6 serial out byte", got, exp_b);
            end
        end
    end

    initial begin
        #3_000_000;
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [15:0] c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        reg_rd(2'd1, v); chk(v == 8'h22, "R5 reset ctrl", v, 8'h22);
        reg_rd(2'd3, v); chk(v == 8'h80, "R9 reset status", v, 8'h80);
        chk(mstop == 1'b1 && irq == 1'b0, "R4 reset outputs", {mstop, irq}, 2'b10);

        // ---------------- transmit ----------------
        mon_wr = 1'b1;
        reg_wr(2'd0, 8'h3C);
        reg_wr(2'd1, 8'hC1);
        expq.push_back(8'h00);
        feed_byte(8'h00);
        peek(); chk(irq == 1'b1, "R8 irq on byte", irq, 1);
        reg_rd(2'd3, v); chk(v[1] == 1'b1, "R3 flag set", v, 8'h82);
        reg_rd(2'd3, v); chk(v[1] == 1'b0, "R3 status read clears", v, 8'h80);
        chk(irq == 1'b1, "R8 status read keeps irq", irq, 1);
        reg_wr(2'd0, 8'h5A);
        peek(); chk(irq == 1'b0, "R8 txd write acks", irq, 0);
        expq.push_back(8'h3C);
        feed_byte(8'h00);
        reg_wr(2'd0, 8'h77);
        reg_rd(2'd3, v); chk(v[1] == 1'b0, "R3 txd write clears flag", v, 8'h80);
        reg_wr(2'd1, 8'hD1);
        peek(); chk(irq == 1'b0, "R8 ctrl write acks", irq, 0);
        c = crc_upd(crc_upd(16'h0, 8'h3C), 8'h5A);
        expq.push_back(8'h5A);
        expq.push_back(c[7:0]);
        expq.push_back(c[15:8]);
        feed_byte(8'h00);
        feed_byte(8'h00);
        feed_byte(8'h00);
        peek(); peek();
        chk(expq.size() == 0, "R6 all bytes seen", expq.size(), 0);
        mon_wr = 1'b0;

        // ---------------- receive with good CRC ----------------
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd1, 8'hC5);
        feed_byte(8'h11);
        peek(); chk(irq == 1'b1, "R8 irq rx byte", irq, 1);
        reg_rd(2'd2, v); chk(v == 8'h11, "R2 rx byte 0", v, 8'h11);
        chk(irq == 1'b0, "R8 rxd read acks", irq, 0);
        reg_rd(2'd3, v); chk(v == 8'h80, "R3 rxd read clears flag", v, 8'h80);
        feed_byte(8'h22);
        reg_rd(2'd2, v); chk(v == 8'h22, "R2 rx byte 1", v, 8'h22);
        c = crc_upd(crc_upd(16'h0, 8'h11), 8'h22);
        reg_wr(2'd1, 8'hD5);
        feed_byte(c[7:0]);
        feed_byte(c[15:8]);
        reg_rd(2'd3, v); chk(v == 8'h82, "R7 good CRC", v, 8'h82);

        // ---------------- receive with bad CRC ----------------
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd1, 8'h45);
        feed_byte(8'h11);
        reg_wr(2'd1, 8'h55);
        feed_byte(8'h00);
        feed_byte(8'h00);
        reg_rd(2'd3, v); chk(v == 8'h92, "R7 bad CRC", v, 8'h92);
        reg_wr(2'd1, 8'h15);
        reg_rd(2'd3, v); chk(v == 8'h80, "R7 cleared by CRC disable", v, 8'h80);

        // ---------------- timing reset ----------------
        reg_wr(2'd1, 8'h05);
        one_tick(1'b1); one_tick(1'b1); one_tick(1'b0);
        reg_wr(2'd1, 8'h04);
        reg_wr(2'd1, 8'h05);
        for (int i = 0; i < 7; i++) one_tick(8'h96 >> i);
        reg_rd(2'd3, v); chk(v == 8'h80, "R4 count restarted", v, 8'h80);
        one_tick(1'b1);
        reg_rd(2'd2, v); chk(v == 8'h96, "R4 byte after restart", v, 8'h96);

        // ---------------- motor halt / mirroring ----------------
        reg_wr(2'd1, 8'h0F);
        peek(); chk(mstop == 1'b1 && mirh == 1'b1, "R4 motor and mirror pins", {mstop, mirh}, 2'b11);
        feed_byte(8'hFF);
        reg_rd(2'd3, v); chk(v == 8'h80, "R4 halt ignores ticks", v, 8'h80);
        reg_rd(2'd1, v); chk(v == 8'h2F, "R5 ctrl readback", v, 8'h2F);

        // ---------------- master enable ----------------
        reg_wr(2'd1, 8'h85);
        feed_byte(8'hA7);
        peek(); chk(irq == 1'b1, "R8 irq before disable", irq, 1);
        en = 1'b0;
        peek(); chk(irq == 1'b0, "R10 irq masked", irq, 0);
        reg_wr(2'd1, 8'h00);
        reg_rd(2'd3, v); chk(v == 8'h00, "R10 read zero", v, 8'h00);
        feed_byte(8'h3E);
        inner = 1'b1;
        en = 1'b1;
        peek(); chk(irq == 1'b0, "R10 pending dropped", irq, 0);
        reg_rd(2'd1, v); chk(v == 8'hA5, "R10 write ignored", v, 8'hA5);
        reg_rd(2'd3, v); chk(v == 8'hC2, "R9 head inner bit", v, 8'hC2);
        reg_rd(2'd2, v); chk(v == 8'hA7, "R10 ticks ignored", v, 8'hA7);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule